// File: doc/BRIEF.md
# Four-Digit Clock Display Scanner with Blinking Colon

This block drives a time-multiplexed display with four common-cathode digits and a separate pair of colon dots. All positions share one set of segment anode lines. The block takes four BCD digits: the tens and units of the hour and of the minute. It also takes a one-hertz phase level. It steps through five scan positions and grounds one cathode at a time. For each position it presents that position's segment pattern on the anode lines.

Positions 4 down to 1 are the time digits, in the order hour tens, hour units, minute tens, minute units. Position 0 is the colon slot. The colon slot carries one of two internal codes, chosen by the phase input. One code lights segments A and B, which are wired to the dots. The other code lights nothing. The dots therefore blink once per second.

The cathodes leave the block as a drive-enable vector and a data vector that is always zero. A pad ring can then release every unselected cathode to high impedance. An internal prescaler sets the scan rate.

Top module: `hhmm_display_scanner`

## Requirements
- R1: While reset is asserted, and until the first refresh strobe after reset, the scan position is 0, `cath_oe` is 5'b00000 and `seg` is 8'h00. `cath_dat` is 5'b00000 at all times.
- R2: After the two-cycle reset synchronizer releases, the refresh strobe fires on every REFRESH_DIV-th clock. Each strobe advances the scan position by exactly one. Between strobes the position holds.
- R3: The position sequence is 0, 1, 2, 3, 4 and then wraps to 0.
- R4: From the first strobe onward, `cath_oe` has exactly one bit set, and that bit is the one whose index equals the current position.
- R5: Position 4 shows `hr_tens`, position 3 shows `hr_units`, position 2 shows `min_tens`, position 1 shows `min_units` and position 0 shows the colon code.
- R6: `seg` is active high, with bit 7 = A down to bit 0 = DP. Codes 0 to 9 give 8'hFC, 8'h60, 8'hDA, 8'hF2, 8'h66, 8'hB6, 8'hBE, 8'hE0, 8'hFE and 8'hF6.
- R7: In the colon slot, `seg` is 8'hC0 (only A and B lit) when `sec_phase` was high at the previous clock edge, and 8'h00 when it was low.
- R8: A digit input of 4'hF shows 8'hC0. Digit codes 10 to 14 show 8'h00.
- R9: Before the first strobe after reset, `seg` is 8'h00 no matter what the digit inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hr_tens | input | 4 | BCD hour tens digit |
| hr_units | input | 4 | BCD hour units digit |
| min_tens | input | 4 | BCD minute tens digit |
| min_units | input | 4 | BCD minute units digit |
| sec_phase | input | 1 | One-hertz phase; high half-period lights the colon |
| cath_oe | output | 5 | Cathode drive enable, bit index = scan position |
| cath_dat | output | 5 | Cathode drive value, always zero |
| seg | output | 8 | Segment anodes A..G, DP (bit 7 = A) |

## Verification
Assertions check four properties on every cycle. The position steps by one on a strobe, wraps from 4 to 0, and holds between strobes. Exactly one cathode enable is set once scanning runs. The strobe never lasts two cycles. The colon slot shows lit or dark according to the sampled phase, and the display stays blank before scanning starts.

Only the bench scenarios show three further things. The first is that each position carries the right digit and the right segment pattern for all ten digits. The second is how invalid codes are decoded. The third is what happens when reset is applied again in the middle of a scan, with timing that follows the synchronizer and prescaler latency.

// File: rtl/scan_pkg.sv
package scan_pkg;
  localparam int unsigned NUM_POS = 5;
  localparam int unsigned POS_W   = 3;
  typedef logic [POS_W-1:0] pos_t;
  localparam logic [3:0] COLON_LIT  = 4'hF;
  localparam logic [3:0] COLON_DARK = 4'hE;
endpackage

// File: rtl/refresh_prescaler.sv
module refresh_prescaler #(
  parameter int unsigned DIV = 10000
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    tick  = (cnt_q == LAST);
    cnt_d = tick ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  generate
    if (DIV > 1) begin : g_chk
      p_tick_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    end
  endgenerate
endmodule

// File: rtl/scan_sequencer.sv
module scan_sequencer
  import scan_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  output pos_t               pos,
  output logic               live,
  output logic [NUM_POS-1:0] oe
);
  pos_t pos_q, pos_d;
  logic live_q, live_d;

  always_comb begin
    pos_d  = pos_q;
    live_d = live_q;
    if (tick) begin
      live_d = 1'b1;
      pos_d  = (pos_q == pos_t'(NUM_POS - 1)) ? '0 : pos_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q  <= '0;
      live_q <= 1'b0;
    end else begin
      pos_q  <= pos_d;
      live_q <= live_d;
    end
  end

  generate
    for (genvar g = 0; g < NUM_POS; g++) begin : g_oe
      assign oe[g] = live_q && (pos_q == pos_t'(g));
    end
  endgenerate

  assign pos  = pos_q;
  assign live = live_q;

  p_advance_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && pos_q != pos_t'(NUM_POS - 1)) |=> pos_q == pos_t'($past(pos_q) + 1'b1));
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(pos_q));
  p_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && pos_q == pos_t'(NUM_POS - 1)) |=> pos_q == '0);
  p_one_cathode_r4: assert property (@(posedge clk) disable iff (!rst_n)
    live_q |-> $countones(oe) == 1);
  p_idle_release_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !live_q |-> (oe == '0 && pos_q == '0));
endmodule

// File: rtl/seg_decoder.sv
module seg_decoder (
  input  logic [3:0] code,
  output logic [7:0] seg
);
  always_comb begin
    unique case (code)
      4'd0:    seg = 8'b1111_1100;
      4'd1:    seg = 8'b0110_0000;
      4'd2:    seg = 8'b1101_1010;
      4'd3:    seg = 8'b1111_0010;
      4'd4:    seg = 8'b0110_0110;
      4'd5:    seg = 8'b1011_0110;
      4'd6:    seg = 8'b1011_1110;
      4'd7:    seg = 8'b1110_0000;
      4'd8:    seg = 8'b1111_1110;
      4'd9:    seg = 8'b1111_0110;
      4'hF:    seg = 8'b1100_0000;
      default: seg = 8'b0000_0000;
    endcase
  end
endmodule

// File: rtl/hhmm_display_scanner.sv
module hhmm_display_scanner
  import scan_pkg::*;
#(
  parameter int unsigned REFRESH_DIV = 10000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] hr_tens,
  input  logic [3:0] hr_units,
  input  logic [3:0] min_tens,
  input  logic [3:0] min_units,
  input  logic       sec_phase,
  output logic [4:0] cath_oe,
  output logic [4:0] cath_dat,
  output logic [7:0] seg
);
  logic rst_meta_q, rst_sync_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  logic phase_q;
  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q) phase_q <= 1'b0;
    else             phase_q <= sec_phase;
  end

  logic tick;
  refresh_prescaler #(.DIV(REFRESH_DIV)) u_presc (
    .clk(clk), .rst_n(rst_sync_q), .tick(tick)
  );

  pos_t pos;
  logic live;
  logic [NUM_POS-1:0] oe;
  scan_sequencer u_seq (
    .clk(clk), .rst_n(rst_sync_q), .tick(tick),
    .pos(pos), .live(live), .oe(oe)
  );

  logic [3:0] code;
  always_comb begin
    unique case (pos)
      3'd4:    code = hr_tens;
      3'd3:    code = hr_units;
      3'd2:    code = min_tens;
      3'd1:    code = min_units;
      default: code = phase_q ? COLON_LIT : COLON_DARK;
    endcase
  end

  logic [7:0] seg_raw;
  seg_decoder u_dec (.code(code), .seg(seg_raw));

  assign seg      = live ? seg_raw : 8'h00;
  assign cath_oe  = oe;
  assign cath_dat = '0;

  p_colon_lit_r7: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (live && pos == '0 && phase_q) |-> seg == 8'hC0);
  p_colon_dark_r7: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (live && pos == '0 && !phase_q) |-> seg == 8'h00);
  p_blank_idle_r9: assert property (@(posedge clk) disable iff (!rst_sync_q)
    !live |-> (seg == 8'h00 && cath_oe == 5'b0));
endmodule

// File: tb/test_hhmm_display_scanner.sv
module test_hhmm_display_scanner;
  localparam int DIV = 3;

  logic clk = 1'b0;
  logic rst_n;
  logic [3:0] hr_tens, hr_units, min_tens, min_units;
  logic sec_phase;
  logic [4:0] cath_oe, cath_dat;
  logic [7:0] seg;

  always #2.5 clk = ~clk;

  hhmm_display_scanner #(.REFRESH_DIV(DIV)) i_hhmm_display_scanner (
    .clk(clk), .rst_n(rst_n), .hr_tens(hr_tens), .hr_units(hr_units),
    .min_tens(min_tens), .min_units(min_units), .sec_phase(sec_phase),
    .cath_oe(cath_oe), .cath_dat(cath_dat), .seg(seg)
  );

  int vectors = 0;
  int fails   = 0;
  bit done    = 0;

  int m_sync = 0, m_n = 0, m_pos = 0;
  bit m_live = 0, m_phase = 0;

  function automatic logic [7:0] pattern(input logic [3:0] c);
    logic [7:0] tbl [10] = '{8'hFC, 8'h60, 8'hDA, 8'hF2, 8'h66,
                             8'hB6, 8'hBE, 8'hE0, 8'hFE, 8'hF6};
    if (c <= 4'd9) return tbl[c];
    if (c == 4'hF) return 8'hC0;
    return 8'h00;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_sync = 0; m_n = 0; m_pos = 0; m_live = 0; m_phase = 0;
    end else if (m_sync < 2) begin
      m_sync++;
    end else begin
      m_phase = sec_phase;
      m_n++;
      if (m_n % DIV == 0) begin
        m_pos  = (m_pos + 1) % 5;
        m_live = 1;
      end
    end
  end

  task automatic compare();
    logic [7:0] e_seg;
    logic [4:0] e_oe;
    logic [3:0] c;
    string tag;
    vectors++;
    e_oe = m_live ? 5'(1 << m_pos) : 5'b0;
    case (m_pos)
      4: c = hr_tens;
      3: c = hr_units;
      2: c = min_tens;
      1: c = min_units;
      default: c = m_phase ? 4'hF : 4'hE;
    endcase
    e_seg = m_live ? pattern(c) : 8'h00;
    if (!m_live)          tag = "R1/R9";
    else if (m_pos == 0)  tag = "R7";
    else if (c > 4'd9)    tag = "R8";
    else                  tag = "R5/R6";
    if (cath_dat !== 5'b0) begin
      fails++;
      $display("FAIL R1 cath_dat actual=%b expected=00000", cath_dat);
    end
    if (cath_oe !== e_oe) begin
      fails++;
      $display("FAIL R2/R3/R4 cath_oe actual=%b expected=%b", cath_oe, e_oe);
    end
    if (seg !== e_seg) begin
      fails++;
      $display("FAIL %s seg pos=%0d actual=%h expected=%h", tag, m_pos, seg, e_seg);
    end
  endtask

  initial begin
    rst_n = 1'b0;
    hr_tens = 4'd1; hr_units = 4'd2; min_tens = 4'd5; min_units = 4'd9;
    sec_phase = 1'b0;
    for (int i = 0; i < 700; i++) begin
      @(negedge clk);
      compare();
      if (i == 3) rst_n = 1'b1;
      if (i == 520) rst_n = 1'b0;
      if (i == 524) rst_n = 1'b1;
      sec_phase = ((i / 7) % 2) == 1;
      case (i / 60)
        0, 1: begin hr_tens = 4'd1; hr_units = 4'd2; min_tens = 4'd5; min_units = 4'd9; end
        2, 3: begin hr_tens = 4'd2; hr_units = 4'd3; min_tens = 4'd4; min_units = 4'd7; end
        4:    begin hr_tens = 4'd0; hr_units = 4'd8; min_tens = 4'd1; min_units = 4'd6; end
        5:    begin hr_tens = 4'd0; hr_units = 4'd0; min_tens = 4'd3; min_units = 4'd0; end
        6, 7: begin hr_tens = 4'd10; hr_units = 4'hF; min_tens = 4'd12; min_units = 4'd14; end
        default: begin hr_tens = 4'd11; hr_units = 4'd13; min_tens = 4'd9; min_units = 4'd6; end
      endcase
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule